// File: doc/BRIEF.md
# Multi-flag doorbell channel unit

This block carries events one way, from a sender to a receiver, across a fixed set of doorbell channels. Each channel holds a word of 32 event flags. Every flag is a transfer of its own: a single bit that says something has happened. No other data goes across. The sender can raise several flags of one channel in a single write, and several transfers can be open on the same channel at once.

The receiver sees one level interrupt per channel. That interrupt stays high while any flag that the receiver has enabled in the channel's mask is set. The receiver writes a clear word to consume flags. When a flag that the sender marked for acknowledge is cleared, the channel's acknowledge interrupt back to the sender goes high. It stays high until the sender dismisses it. Each side also has one combined interrupt, which is the OR of that side's per-channel lines. Both sides can read back the number of channels that were built.

Top module: `dbell_mbox`

## Requirements
- R1: After a synchronous reset, every flag word, mask word, acknowledge-enable word and acknowledge status is zero, and every interrupt output is low.
- R2: A sender write with `s_wsel`=0 (set) to channel c ORs each 1 bit of `s_wdata` into channel c's flag word. 0 bits leave their flags unchanged, and other channels are unaffected.
- R3: A receiver write with `r_wsel`=0 (clear) to channel c clears each flag whose `r_wdata` bit is 1. Flags whose bit is 0 are unchanged.
- R4: If the same flag is set by the sender and cleared by the receiver at the same clock edge, the flag ends up set, and no acknowledge is raised for it.
- R5: The receiver writes channel c's mask with `r_wsel`=1, where a 1 bit enables that flag. `rx_irq[c]` is high exactly while (flags AND mask) of channel c is non-zero. It updates at the same clock edge as the write that changes either word.
- R6: The sender writes channel c's acknowledge-enable word with `s_wsel`=1. A receiver clear that removes a set flag whose enable bit is 1 drives `tx_ack_irq[c]` high at that edge. Clearing a flag whose enable bit is 0 raises nothing. The status holds until a sender write with `s_wsel`=2 and `s_wdata[0]`=1 to channel c; with `s_wdata[0]`=0 that write has no effect.
- R7: `rx_comb_irq` equals the OR of all `rx_irq` bits and `tx_comb_irq` equals the OR of all `tx_ack_irq` bits, in the same cycle.
- R8: A read with select 3 returns the number of channels, NUM_CH, on either side.
- R9: Writes addressed to a channel index of NUM_CH or above change no state, and reads of such an index with select 0, 1 or 2 return zero.
- R10: A read pulse returns data in the following cycle. Sender select 0 gives the flags, 1 the acknowledge-enable word, and 2 the acknowledge status in bit 0. Receiver select 0 gives the flags, 1 the mask, and 2 flags AND mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_wr | input | 1 | Sender write strobe |
| s_wsel | input | 2 | Sender write select: 0 set, 1 ack enable, 2 ack dismiss, 3 none |
| s_wch | input | CH_W | Sender write channel |
| s_wdata | input | FLAG_W | Sender write data |
| s_rd | input | 1 | Sender read strobe |
| s_rsel | input | 2 | Sender read select |
| s_rch | input | CH_W | Sender read channel |
| s_rdata | output | FLAG_W | Sender read data, one cycle after s_rd |
| r_wr | input | 1 | Receiver write strobe |
| r_wsel | input | 1 | Receiver write select: 0 clear, 1 mask |
| r_wch | input | CH_W | Receiver write channel |
| r_wdata | input | FLAG_W | Receiver write data |
| r_rd | input | 1 | Receiver read strobe |
| r_rsel | input | 2 | Receiver read select |
| r_rch | input | CH_W | Receiver read channel |
| r_rdata | output | FLAG_W | Receiver read data, one cycle after r_rd |
| rx_irq | output | NUM_CH | Per-channel transfer interrupt to the receiver |
| tx_ack_irq | output | NUM_CH | Per-channel acknowledge interrupt to the sender |
| rx_comb_irq | output | 1 | OR of all receiver interrupts |
| tx_comb_irq | output | 1 | OR of all sender acknowledge interrupts |

## Verification
The bench builds the block with NUM_CH=5. The channel index is then 3 bits wide, and indices 5 to 7 are decodable but unbuilt, so the ignore-and-read-zero behaviour of R9 can be reached. Five channels also make the count register return a value that is not a power of two. The default FLAG_W of 32 exercises the top flag bit as well as bit 0. This covers the collision of set and clear at the same edge and acknowledges raised on one channel while others hold flags.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int FLAGS_PER_CH = 32;

  // sender write selects
  localparam logic [1:0] SW_SET    = 2'd0;
  localparam logic [1:0] SW_ACKEN  = 2'd1;
  localparam logic [1:0] SW_ACKCLR = 2'd2;

  // receiver write selects
  localparam logic RW_CLEAR = 1'b0;
  localparam logic RW_MASK  = 1'b1;

  // read selects (shared layout on both sides)
  localparam logic [1:0] RD_W0    = 2'd0;
  localparam logic [1:0] RD_W1    = 2'd1;
  localparam logic [1:0] RD_W2    = 2'd2;
  localparam logic [1:0] RD_COUNT = 2'd3;
endpackage

// File: rtl/dbell_chan.sv
module dbell_chan #(
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic [FLAG_W-1:0] set_data,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] clr_data,
  input  logic              mask_we,
  input  logic [FLAG_W-1:0] mask_data,
  input  logic              acken_we,
  input  logic [FLAG_W-1:0] acken_data,
  input  logic              ackclr_we,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] mask_q,
  output logic [FLAG_W-1:0] acken_q,
  output logic              ack_q,
  output logic              irq_q,
  output logic              irq_d,
  output logic              ack_d
);
  logic [FLAG_W-1:0] set_v, clr_v, flags_d, mask_d, acken_d;
  logic              ack_evt;

  always_comb begin
    set_v   = set_we ? set_data : '0;
    clr_v   = clr_we ? clr_data : '0;
    // a simultaneous set keeps the flag alive
    flags_d = (flags_q & ~clr_v) | set_v;
    mask_d  = mask_we  ? mask_data  : mask_q;
    acken_d = acken_we ? acken_data : acken_q;
    ack_evt = |(flags_q & clr_v & ~set_v & acken_q);
    ack_d   = ack_evt | (ack_q & ~ackclr_we);
    irq_d   = |(flags_d & mask_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      acken_q <= '0;
      ack_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      mask_q  <= mask_d;
      acken_q <= acken_d;
      ack_q   <= ack_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/dbell_rdport.sv
module dbell_rdport #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int FLAG_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd,
  input  logic [1:0]                   rsel,
  input  logic [CH_W-1:0]              rch,
  input  logic [NUM_CH-1:0][FLAG_W-1:0] word0,
  input  logic [NUM_CH-1:0][FLAG_W-1:0] word1,
  input  logic [NUM_CH-1:0][FLAG_W-1:0] word2,
  output logic [FLAG_W-1:0]            rdata
);
  import dbell_pkg::*;

  logic [FLAG_W-1:0] rd_d;
  logic              in_range;

  always_comb begin
    in_range = int'(rch) < NUM_CH;
    rd_d     = '0;
    if (rsel == RD_COUNT) begin
      rd_d = FLAG_W'(NUM_CH);
    end else if (in_range) begin
      case (rsel)
        RD_W0:   rd_d = word0[rch];
        RD_W1:   rd_d = word1[rch];
        default: rd_d = word2[rch];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_d;
  end
endmodule

// File: rtl/dbell_irqtree.sv
module dbell_irqtree #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rx_d,
  input  logic [NUM_CH-1:0] ack_d,
  output logic              rx_comb_irq,
  output logic              tx_comb_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_comb_irq <= 1'b0;
      tx_comb_irq <= 1'b0;
    end else begin
      rx_comb_irq <= |rx_d;
      tx_comb_irq <= |ack_d;
    end
  end
endmodule

// File: rtl/dbell_mbox.sv
module dbell_mbox #(
  parameter int NUM_CH = 4,
  parameter int FLAG_W = dbell_pkg::FLAGS_PER_CH,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_wr,
  input  logic [1:0]        s_wsel,
  input  logic [CH_W-1:0]   s_wch,
  input  logic [FLAG_W-1:0] s_wdata,
  input  logic              s_rd,
  input  logic [1:0]        s_rsel,
  input  logic [CH_W-1:0]   s_rch,
  output logic [FLAG_W-1:0] s_rdata,
  input  logic              r_wr,
  input  logic              r_wsel,
  input  logic [CH_W-1:0]   r_wch,
  input  logic [FLAG_W-1:0] r_wdata,
  input  logic              r_rd,
  input  logic [1:0]        r_rsel,
  input  logic [CH_W-1:0]   r_rch,
  output logic [FLAG_W-1:0] r_rdata,
  output logic [NUM_CH-1:0] rx_irq,
  output logic [NUM_CH-1:0] tx_ack_irq,
  output logic              rx_comb_irq,
  output logic              tx_comb_irq
);
  import dbell_pkg::*;

  logic [NUM_CH-1:0][FLAG_W-1:0] flags_a, mask_a, acken_a, ackst_a, pend_a;
  logic [NUM_CH-1:0]             irq_nx, ack_nx;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_s, hit_r;
    assign hit_s = s_wr && (s_wch == CH_W'(c));
    assign hit_r = r_wr && (r_wch == CH_W'(c));

    dbell_chan #(.FLAG_W(FLAG_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .set_we     (hit_s && (s_wsel == SW_SET)),
      .set_data   (s_wdata),
      .clr_we     (hit_r && (r_wsel == RW_CLEAR)),
      .clr_data   (r_wdata),
      .mask_we    (hit_r && (r_wsel == RW_MASK)),
      .mask_data  (r_wdata),
      .acken_we   (hit_s && (s_wsel == SW_ACKEN)),
      .acken_data (s_wdata),
      .ackclr_we  (hit_s && (s_wsel == SW_ACKCLR) && s_wdata[0]),
      .flags_q    (flags_a[c]),
      .mask_q     (mask_a[c]),
      .acken_q    (acken_a[c]),
      .ack_q      (tx_ack_irq[c]),
      .irq_q      (rx_irq[c]),
      .irq_d      (irq_nx[c]),
      .ack_d      (ack_nx[c])
    );

    assign ackst_a[c] = {{(FLAG_W-1){1'b0}}, tx_ack_irq[c]};
    assign pend_a[c]  = flags_a[c] & mask_a[c];
  end

  dbell_rdport #(.NUM_CH(NUM_CH), .CH_W(CH_W), .FLAG_W(FLAG_W)) u_srd (
    .clk(clk), .rst(rst), .rd(s_rd), .rsel(s_rsel), .rch(s_rch),
    .word0(flags_a), .word1(acken_a), .word2(ackst_a), .rdata(s_rdata)
  );

  dbell_rdport #(.NUM_CH(NUM_CH), .CH_W(CH_W), .FLAG_W(FLAG_W)) u_rrd (
    .clk(clk), .rst(rst), .rd(r_rd), .rsel(r_rsel), .rch(r_rch),
    .word0(flags_a), .word1(mask_a), .word2(pend_a), .rdata(r_rdata)
  );

  dbell_irqtree #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst(rst), .rx_d(irq_nx), .ack_d(ack_nx),
    .rx_comb_irq(rx_comb_irq), .tx_comb_irq(tx_comb_irq)
  );
endmodule

// File: rtl/dbell_mbox_chk.sv
module dbell_mbox_chk #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              s_wr,
  input logic [1:0]        s_wsel,
  input logic [CH_W-1:0]   s_wch,
  input logic              s_dismiss_bit,
  input logic              r_wr,
  input logic              r_wsel,
  input logic [CH_W-1:0]   r_wch,
  input logic [NUM_CH-1:0] rx_irq,
  input logic [NUM_CH-1:0] tx_ack_irq,
  input logic              rx_comb_irq,
  input logic              tx_comb_irq
);
  import dbell_pkg::*;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (rx_irq == '0 && tx_ack_irq == '0 && !rx_comb_irq && !tx_comb_irq));

  // R7
  comb_or_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_comb_irq == (|rx_irq)) && (tx_comb_irq == (|tx_ack_irq)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic set_c, clr_c, mask_c, dis_c;
    assign set_c  = s_wr && s_wsel == SW_SET && s_wch == CH_W'(c);
    assign dis_c  = s_wr && s_wsel == SW_ACKCLR && s_wch == CH_W'(c) && s_dismiss_bit;
    assign clr_c  = r_wr && r_wsel == RW_CLEAR && r_wch == CH_W'(c);
    assign mask_c = r_wr && r_wsel == RW_MASK && r_wch == CH_W'(c);

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (!rx_irq[c] && !set_c && !mask_c) |=> !rx_irq[c]);

    // R3
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_irq[c] && !clr_c && !mask_c) |=> rx_irq[c]);

    // R6
    ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (!tx_ack_irq[c] && !clr_c) |=> !tx_ack_irq[c]);

    // R6
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_ack_irq[c] && !dis_c) |=> tx_ack_irq[c]);
  end
endmodule

bind dbell_mbox dbell_mbox_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst(rst), .s_wr(s_wr), .s_wsel(s_wsel), .s_wch(s_wch),
  .s_dismiss_bit(s_wdata[0]), .r_wr(r_wr), .r_wsel(r_wsel), .r_wch(r_wch),
  .rx_irq(rx_irq), .tx_ack_irq(tx_ack_irq),
  .rx_comb_irq(rx_comb_irq), .tx_comb_irq(tx_comb_irq)
);

// File: tb/dbell_mbox_tb.sv
`timescale 1ns/100ps
module dbell_mbox_tb;
  localparam int NC = 5;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic s_wr = 0, s_rd = 0, r_wr = 0, r_rd = 0, r_wsel = 0;
  logic [1:0] s_wsel = 0, s_rsel = 0, r_rsel = 0;
  logic [CW-1:0] s_wch = 0, s_rch = 0, r_wch = 0, r_rch = 0;
  logic [31:0] s_wdata = 0, r_wdata = 0, s_rdata, r_rdata;
  logic [NC-1:0] rx_irq, tx_ack_irq;
  logic rx_comb_irq, tx_comb_irq;

  dbell_mbox #(.NUM_CH(NC)) u_dut (
    .clk(clk), .rst(rst),
    .s_wr(s_wr), .s_wsel(s_wsel), .s_wch(s_wch), .s_wdata(s_wdata),
    .s_rd(s_rd), .s_rsel(s_rsel), .s_rch(s_rch), .s_rdata(s_rdata),
    .r_wr(r_wr), .r_wsel(r_wsel), .r_wch(r_wch), .r_wdata(r_wdata),
    .r_rd(r_rd), .r_rsel(r_rsel), .r_rch(r_rch), .r_rdata(r_rdata),
    .rx_irq(rx_irq), .tx_ack_irq(tx_ack_irq),
    .rx_comb_irq(rx_comb_irq), .tx_comb_irq(tx_comb_irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // requirement-level model
  logic [31:0] mflags [NC], mmask [NC], macken [NC];
  logic [NC-1:0] mack;

  // scoreboard queues
  logic [31:0] sq_exp[$], rq_exp[$];
  string       sq_tag[$], rq_tag[$];
  logic s_pend = 0, r_pend = 0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_rx();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = |(mflags[c] & mmask[c]);
    return v;
  endfunction

  always @(posedge clk) begin
    s_pend <= s_rd;
    r_pend <= r_rd;
  end

  // monitor: pops the expected read values as results appear
  always @(negedge clk) begin
    if (s_pend && sq_exp.size() > 0) chk(s_rdata, sq_exp.pop_front(), sq_tag.pop_front());
    if (r_pend && rq_exp.size() > 0) chk(r_rdata, rq_exp.pop_front(), rq_tag.pop_front());
  end

  task automatic s_write(input logic [1:0] sel, input int ch, input logic [31:0] d);
    s_wr = 1; s_wsel = sel; s_wch = CW'(ch); s_wdata = d;
    if (ch < NC) begin
      if (sel == 2'd0) mflags[ch] = mflags[ch] | d;
      else if (sel == 2'd1) macken[ch] = d;
      else if (sel == 2'd2 && d[0]) mack[ch] = 1'b0;
    end
    @(negedge clk);
    s_wr = 0;
  endtask

  task automatic r_write(input logic sel, input int ch, input logic [31:0] d);
    r_wr = 1; r_wsel = sel; r_wch = CW'(ch); r_wdata = d;
    if (ch < NC) begin
      if (sel == 1'b0) begin
        if (|(mflags[ch] & d & macken[ch])) mack[ch] = 1'b1;
        mflags[ch] = mflags[ch] & ~d;
      end else mmask[ch] = d;
    end
    @(negedge clk);
    r_wr = 0;
  endtask

  task automatic collide(input int ch, input logic [31:0] sd, input logic [31:0] cd);
    s_wr = 1; s_wsel = 2'd0; s_wch = CW'(ch); s_wdata = sd;
    r_wr = 1; r_wsel = 1'b0; r_wch = CW'(ch); r_wdata = cd;
    if (|(mflags[ch] & cd & ~sd & macken[ch])) mack[ch] = 1'b1;
    mflags[ch] = (mflags[ch] & ~cd) | sd;
    @(negedge clk);
    s_wr = 0; r_wr = 0;
  endtask

  task automatic s_read(input logic [1:0] sel, input int ch, input logic [31:0] exp, input string tag);
    s_rd = 1; s_rsel = sel; s_rch = CW'(ch);
    sq_exp.push_back(exp); sq_tag.push_back(tag);
    @(negedge clk);
    s_rd = 0;
  endtask

  task automatic r_read(input logic [1:0] sel, input int ch, input logic [31:0] exp, input string tag);
    r_rd = 1; r_rsel = sel; r_rch = CW'(ch);
    rq_exp.push_back(exp); rq_tag.push_back(tag);
    @(negedge clk);
    r_rd = 0;
  endtask

  task automatic chk_irqs(input string tag);
    chk(32'(rx_irq), 32'(exp_rx()), {tag, " rx_irq"});
    chk(32'(tx_ack_irq), 32'(mack), {tag, " tx_ack_irq"});
    chk(32'(rx_comb_irq), 32'(|exp_rx()), {"R7 ", tag, " rx_comb"});
    chk(32'(tx_comb_irq), 32'(|mack), {"R7 ", tag, " tx_comb"});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin
      mflags[c] = 0; mmask[c] = 0; macken[c] = 0;
    end
    mack = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_irqs("R1 reset");
    r_read(2'd0, 2, 32'h0, "R1 flags after reset");
    r_read(2'd1, 4, 32'h0, "R1 mask after reset");
    s_read(2'd1, 0, 32'h0, "R1 acken after reset");
    // R8 channel count
    s_read(2'd3, 0, 32'd5, "R8 sender count");
    r_read(2'd3, 6, 32'd5, "R8 receiver count");
    // R2 set ORs bits
    s_write(2'd0, 1, 32'h0000_00F0);
    s_write(2'd0, 1, 32'h0000_0003);
    r_read(2'd0, 1, 32'h0000_00F3, "R2 flags after two sets");
    r_read(2'd0, 0, 32'h0, "R2 other channel untouched");
    chk_irqs("R5 masked flags");
    // R5 mask enables interrupt
    r_write(1'b1, 1, 32'h0000_0002);
    chk_irqs("R5 mask on");
    r_read(2'd2, 1, 32'h0000_0002, "R10 pending word");
    // R3 clear
    r_write(1'b0, 1, 32'h0000_0010);
    chk_irqs("R3 clear unmasked flag");
    r_write(1'b0, 1, 32'h0000_0002);
    chk_irqs("R5 last enabled flag cleared");
    r_read(2'd0, 1, 32'h0000_00E1, "R3 flags after clears");
    // R4 collision
    s_write(2'd0, 3, 32'h8000_0001);
    r_write(1'b1, 3, 32'hFFFF_FFFF);
    s_write(2'd1, 3, 32'h8000_0001);
    collide(3, 32'h8000_0000, 32'h8000_0000);
    chk_irqs("R4 set wins, no ack");
    r_read(2'd0, 3, 32'h8000_0001, "R4 flags after collision");
    // R6 acknowledge
    r_write(1'b0, 3, 32'h0000_0001);
    chk_irqs("R6 ack raised");
    s_read(2'd2, 3, 32'h1, "R6 ack status read");
    s_read(2'd1, 3, 32'h8000_0001, "R10 acken readback");
    r_write(1'b0, 1, 32'h0000_0001);
    chk_irqs("R6 clear without enable");
    s_write(2'd2, 3, 32'h0000_0000);
    chk_irqs("R6 dismiss with bit0=0 ignored");
    s_write(2'd2, 3, 32'h0000_0001);
    chk_irqs("R6 dismissed");
    // R9 out of range
    s_write(2'd0, 6, 32'hFFFF_FFFF);
    r_write(1'b1, 7, 32'hFFFF_FFFF);
    chk_irqs("R9 out of range writes");
    r_read(2'd0, 6, 32'h0, "R9 read unbuilt channel");
    r_read(2'd0, 0, 32'h0, "R9 ch0 untouched");
    // multi-channel
    s_write(2'd0, 0, 32'h0000_0100);
    s_write(2'd0, 4, 32'h0001_0000);
    r_write(1'b1, 4, 32'h0001_0000);
    r_write(1'b1, 0, 32'h0000_0100);
    chk_irqs("R5 several channels");
    s_read(2'd0, 4, 32'h0001_0000, "R10 sender flags read");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule